// File: doc/BRIEF.md
# Burst Column Engine

This block is the data engine for the memory side of one open row. When a read or write command arrives it takes the start column and steps through a burst of columns. The number of beats is set by a burst-length select, and the visiting order is either sequential or interleaved. The column always stays inside the block of columns that is aligned to the burst length. A simple register file holds the row's words.

Write data for the first column is taken on the same clock edge as the write command. Read data appears after a selectable CAS latency. A separate output-enable marks the read data instead of a tri-state bus. Read bursts that follow each other with no idle cycle give one unbroken stream of output-enable.

Four byte-mask inputs gate the 32-bit lanes, one bit per byte lane. On a write the mask blocks the byte on the edge where it is sampled. On a read the mask blanks the byte two cycles later. A new command cuts off any burst in progress and starts again from its own column.

Top module: `burst_col_engine`

## Requirements
- R1: While reset is held and after it is released with no command, `rdDataOe` is 0 and `rdData` is all zeros.
- R2: A read beat issued on edge e shows up on `rdData` with `rdDataOe`=1 after edge e+`casLatency`, for `casLatency` 1, 2 or 3. It is not yet present after edge e+`casLatency`-1.
- R3: `burstLenSel` 0/1/2/3 gives a burst of 1/2/4/8 beats. For beat k with BL beats, the low log2(BL) column bits are (start+k) mod BL when `burstOrder`=0 (sequential), or start XOR k when `burstOrder`=1 (interleaved). The upper column bits stay those of the start column.
- R4: On a write, beat 0 stores the `wrData` sampled on the command edge at the start column. Each later beat stores the `wrData` of the next consecutive edge.
- R5: `rdDataOe` is 1 exactly during the output cycles of issued read beats. Back-to-back reads keep it high with no gap, and it drops after the last beat. Whenever `rdDataOe` is 0, `rdData` is zero.
- R6: If `byteMask[i]` is 1 when sampled on edge m, byte lane i (bits 8i+7:8i) of `rdData` is zero in the output cycle after edge m+2.
- R7: If `byteMask[i]` is 1 on the edge of a write beat, byte lane i of that column keeps its old contents. The other lanes are written.
- R8: A command sampled while a burst is running ends that burst at once. No further beats of the old burst are issued, and sequencing restarts from the new column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command strobe, one cycle |
| cmdWrite | input | 1 | 1 = write burst, 0 = read burst |
| cmdCol | input | COL_W | Start column of the burst |
| burstLenSel | input | 2 | Burst length select: 0=1, 1=2, 2=4, 3=8 beats |
| burstOrder | input | 1 | 0 = sequential, 1 = interleaved |
| casLatency | input | CL_W | Read latency in cycles, 1 to MAX_CL; held stable while reads are outstanding |
| byteMask | input | DATA_W/8 | Per-lane mask, bit i covers bits 8i+7:8i |
| wrData | input | DATA_W | Write data for the current beat |
| rdData | output | DATA_W | Read data, zero when not enabled |
| rdDataOe | output | 1 | Read data valid / bus drive enable |

## Verification
The bench starts bursts at columns that are not aligned, in both orders, and checks where each beat lands. A design that wraps past the aligned block, or adds where it should XOR, corrupts neighbouring words. It interrupts a write burst with a read and confirms the untouched column kept its old value. A design that lets the old burst keep going would overwrite it. It chains two reads with no idle cycle, checks that output-enable stays high for four cycles in a row, and checks that it drops one cycle later. Masks placed on the command edge and chosen at random check that reads are blanked two cycles late and writes in the same cycle. Getting either delay wrong shows up as wrong bytes in the output stream.

// File: rtl/bce_pkg.sv
package bce_pkg;

  typedef struct packed {
    logic rdIssue;
    logic wrIssue;
  } beatStrobe_t;

  typedef enum logic {
    ORDER_SEQ = 1'b0,
    ORDER_ILV = 1'b1
  } burstOrder_t;

  function automatic logic [2:0] lenMaskOf(input logic [1:0] sel);
    case (sel)
      2'd0:    return 3'b000;
      2'd1:    return 3'b001;
      2'd2:    return 3'b011;
      default: return 3'b111;
    endcase
  endfunction

endpackage

// File: rtl/bce_ctrl.sv
module bce_ctrl
  import bce_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic             cmdWrite,
  input  logic [COL_W-1:0] cmdCol,
  input  logic [1:0]       burstLenSel,
  input  logic             burstOrder,
  output beatStrobe_t      strobe,
  output logic [COL_W-1:0] beatCol
);

  logic             busyQ, wrQ, ilvQ;
  logic [2:0]       lenQ, beatQ;
  logic [COL_W-1:0] startQ;

  logic             act, wr, ilv;
  logic [2:0]       k, lenM, low3, newLow;
  logic [COL_W-1:0] start;

  // a new command always takes over from a running burst
  always_comb begin
    act   = 1'b0;
    wr    = wrQ;
    ilv   = ilvQ;
    k     = beatQ;
    lenM  = lenQ;
    start = startQ;
    if (cmdValid) begin
      act   = 1'b1;
      wr    = cmdWrite;
      ilv   = (burstOrder_t'(burstOrder) == ORDER_ILV);
      k     = 3'd0;
      lenM  = lenMaskOf(burstLenSel);
      start = cmdCol;
    end else if (busyQ) begin
      act = 1'b1;
    end
    low3    = ilv ? (start[2:0] ^ k) : (start[2:0] + k);
    newLow  = (start[2:0] & ~lenM) | (low3 & lenM);
    beatCol = {start[COL_W-1:3], newLow};
    strobe.rdIssue = act & ~wr;
    strobe.wrIssue = act & wr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      wrQ    <= 1'b0;
      ilvQ   <= 1'b0;
      lenQ   <= 3'd0;
      beatQ  <= 3'd0;
      startQ <= '0;
    end else if (act) begin
      busyQ  <= (k != lenM);
      beatQ  <= k + 3'd1;
      wrQ    <= wr;
      ilvQ   <= ilv;
      lenQ   <= lenM;
      startQ <= start;
    end
  end

  logic [COL_W-1:0] blockMaskQ;
  assign blockMaskQ = {{(COL_W-3){1'b1}}, ~lenQ};

  // R3
  beat_in_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && !cmdValid) |-> ((beatCol & blockMaskQ) == (startQ & blockMaskQ)));

  // R3
  beat_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    busyQ |-> (beatQ <= lenQ));

  // R8
  restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> (beatQ == 3'd1));

  // R8
  restart_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> (busyQ == ($past(burstLenSel) != 2'd0)));

endmodule

// File: rtl/bce_data.sv
module bce_data
  import bce_pkg::*;
#(
  parameter int COL_W  = 8,
  parameter int DATA_W = 32,
  parameter int MAX_CL = 3,
  localparam int LANES = DATA_W / 8,
  localparam int DEPTH = 1 << COL_W,
  localparam int CL_W  = $clog2(MAX_CL + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  beatStrobe_t       strobe,
  input  logic [COL_W-1:0]  beatCol,
  input  logic [CL_W-1:0]   casLatency,
  input  logic [LANES-1:0]  byteMask,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdDataOe
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdPipe [MAX_CL+1];
  logic [MAX_CL:0]   vPipe;
  logic [LANES-1:0]  mDly [3];

  // write lanes: mask acts on the same edge
  always_ff @(posedge clk) begin
    if (strobe.wrIssue) begin
      for (int l = 0; l < LANES; l++) begin
        if (!byteMask[l]) mem[beatCol][l*8 +: 8] <= wrData[l*8 +: 8];
      end
    end
  end

  // read data pipeline, output picked by the latency select
  always_ff @(posedge clk) begin
    rdPipe[0] <= mem[beatCol];
    for (int i = 1; i <= MAX_CL; i++) rdPipe[i] <= rdPipe[i-1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vPipe <= '0;
      for (int i = 0; i < 3; i++) mDly[i] <= '0;
    end else begin
      vPipe <= {vPipe[MAX_CL-1:0], strobe.rdIssue};
      mDly[0] <= byteMask;
      mDly[1] <= mDly[0];
      mDly[2] <= mDly[1];
    end
  end

  always_comb begin
    rdDataOe = vPipe[casLatency];
    for (int l = 0; l < LANES; l++) begin
      rdData[l*8 +: 8] = (rdDataOe && !mDly[2][l]) ? rdPipe[casLatency][l*8 +: 8] : 8'h00;
    end
  end

  // R2
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdDataOe == ((casLatency == CL_W'(1)) ? $past(strobe.rdIssue, 2) :
                 (casLatency == CL_W'(2)) ? $past(strobe.rdIssue, 3) :
                                            $past(strobe.rdIssue, 4)));

  // R5
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdDataOe |-> (rdData == '0));

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    // R6
    read_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
      $past(byteMask[l], 3) |-> (rdData[l*8 +: 8] == 8'h00));
  end

endmodule

// File: rtl/burst_col_engine.sv
module burst_col_engine
  import bce_pkg::*;
#(
  parameter int COL_W  = 8,
  parameter int DATA_W = 32,
  parameter int MAX_CL = 3,
  localparam int LANES = DATA_W / 8,
  localparam int CL_W  = $clog2(MAX_CL + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic              cmdWrite,
  input  logic [COL_W-1:0]  cmdCol,
  input  logic [1:0]        burstLenSel,
  input  logic              burstOrder,
  input  logic [CL_W-1:0]   casLatency,
  input  logic [LANES-1:0]  byteMask,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdDataOe
);

  beatStrobe_t      strobe;
  logic [COL_W-1:0] beatCol;

  bce_ctrl #(.COL_W(COL_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdWrite(cmdWrite),
    .cmdCol(cmdCol), .burstLenSel(burstLenSel), .burstOrder(burstOrder),
    .strobe(strobe), .beatCol(beatCol)
  );

  bce_data #(.COL_W(COL_W), .DATA_W(DATA_W), .MAX_CL(MAX_CL)) i_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .beatCol(beatCol),
    .casLatency(casLatency), .byteMask(byteMask), .wrData(wrData),
    .rdData(rdData), .rdDataOe(rdDataOe)
  );

endmodule

// File: tb/test_burst_col_engine.sv
`timescale 1ns/1ps
module test_burst_col_engine;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0, cmdWrite = 1'b0, burstOrder = 1'b0;
  logic [7:0]  cmdCol = '0;
  logic [1:0]  burstLenSel = '0;
  logic [1:0]  casLatency = 2'd2;
  logic [3:0]  byteMask = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        rdDataOe;

  always #2.5 clk = ~clk;

  burst_col_engine i_burst_col_engine (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdWrite(cmdWrite),
    .cmdCol(cmdCol), .burstLenSel(burstLenSel), .burstOrder(burstOrder),
    .casLatency(casLatency), .byteMask(byteMask), .wrData(wrData),
    .rdData(rdData), .rdDataOe(rdDataOe)
  );

  int checks = 0, errors = 0;

  function automatic logic [31:0] initVal(input logic [7:0] c);
    return {c ^ 8'hC3, c, ~c, 8'h5A};
  endfunction

  function automatic logic [31:0] laneMask(input logic [3:0] m);
    return {{8{m[3]}}, {8{m[2]}}, {8{m[1]}}, {8{m[0]}}};
  endfunction

  function automatic logic [7:0] colOf(input logic [7:0] s, input logic [1:0] sel,
                                       input logic ilv, input logic [2:0] k);
    logic [2:0] m, low;
    m   = (sel == 0) ? 3'd0 : (sel == 1) ? 3'd1 : (sel == 2) ? 3'd3 : 3'd7;
    low = ilv ? (s[2:0] ^ k) : (s[2:0] + k);
    return {s[7:3], (s[2:0] & ~m) | (low & m)};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  // ---------------- reference model (from requirements) ----------------
  logic [31:0] mMem [256];
  logic        eOe [8];
  logic [31:0] eDat [8];
  logic [3:0]  eMsk [8];
  int unsigned cyc = 0;
  logic        mBusy = 0, mWr = 0, mIlv = 0, chkEn = 0;
  logic [1:0]  mSel = 0;
  logic [7:0]  mStart = 0;
  logic [2:0]  mK = 0;

  initial for (int i = 0; i < 8; i++) begin eOe[i] = 0; eDat[i] = 0; eMsk[i] = 0; end

  always @(posedge clk) begin
    if (!rstN) mBusy = 0;
    else begin
      logic act;
      logic [7:0] col;
      logic [2:0] lastK;
      cyc++;
      act = cmdValid || mBusy;
      if (cmdValid) begin
        mWr = cmdWrite; mIlv = burstOrder; mSel = burstLenSel; mStart = cmdCol; mK = 0;
      end
      if (act) begin
        col = colOf(mStart, mSel, mIlv, mK);
        if (mWr) begin
          for (int l = 0; l < 4; l++)
            if (!byteMask[l]) mMem[col][l*8 +: 8] = wrData[l*8 +: 8];
        end else begin
          eOe[(cyc + casLatency) % 8]  = 1'b1;
          eDat[(cyc + casLatency) % 8] = mMem[col];
        end
        lastK = (mSel == 0) ? 3'd0 : (mSel == 1) ? 3'd1 : (mSel == 2) ? 3'd3 : 3'd7;
        mBusy = (mK != lastK);
        mK = mK + 3'd1;
      end
      eMsk[(cyc + 2) % 8] = byteMask;
    end
  end

  always @(negedge clk) begin
    if (chkEn) begin
      int s;
      logic [31:0] exp;
      s = cyc % 8;
      exp = eOe[s] ? (eDat[s] & ~laneMask(eMsk[s])) : 32'h0;
      chk("R5 oe", {31'b0, rdDataOe}, {31'b0, eOe[s]});
      chk("R2 R6 data", rdData, exp);
      eOe[s] = 1'b0;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeBurst(input logic [7:0] col, input logic [1:0] sel, input logic ilv,
                            input logic [31:0] base, input logic [3:0] msk);
    int bl;
    bl = 1 << sel;
    cmdValid = 1; cmdWrite = 1; cmdCol = col; burstLenSel = sel; burstOrder = ilv;
    for (int k = 0; k < bl; k++) begin
      wrData = base + k; byteMask = msk;
      @(negedge clk);
      cmdValid = 0;
    end
    byteMask = 0;
  endtask

  task automatic readOne(input logic [7:0] col, input logic [3:0] msk, output logic [31:0] d,
                         output logic oe);
    cmdValid = 1; cmdWrite = 0; cmdCol = col; burstLenSel = 0; byteMask = msk;
    @(negedge clk);
    cmdValid = 0; byteMask = 0;
    repeat (casLatency) @(negedge clk);
    d = rdData; oe = rdDataOe;
  endtask

  // ---------------- watchdog ----------------
  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd == 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    logic [31:0] d;
    logic oe;
    void'($urandom(32'h5EED1234));
    repeat (4) @(negedge clk);
    // R1: reset state while held
    chk("R1 oe in reset", {31'b0, rdDataOe}, 32'h0);
    chk("R1 data in reset", rdData, 32'h0);
    rstN = 1;
    idle(2);
    chk("R1 oe after reset", {31'b0, rdDataOe}, 32'h0);
    chk("R1 data after reset", rdData, 32'h0);
    chkEn = 1;

    // fill all columns with known words, 8-beat sequential bursts
    for (int c = 0; c < 256; c += 8) begin
      cmdValid = 1; cmdWrite = 1; cmdCol = 8'(c); burstLenSel = 3; burstOrder = 0;
      for (int k = 0; k < 8; k++) begin
        wrData = initVal(8'(c + k));
        @(negedge clk);
        cmdValid = 0;
      end
    end
    idle(2);

    // R3 / R4: unaligned sequential 4-beat write at col 6 -> 6,7,4,5
    writeBurst(8'd6, 2'd2, 1'b0, 32'd100, 4'h0);
    idle(2);
    readOne(8'd4, 4'h0, d, oe); chk("R3 seq wrap col4", d, 32'd102);
    idle(4);
    readOne(8'd7, 4'h0, d, oe); chk("R4 beat1 col7", d, 32'd101);
    idle(4);
    readOne(8'd6, 4'h0, d, oe); chk("R4 beat0 col6", d, 32'd100);
    idle(4);

    // R3: interleaved 8-beat write at col 13 -> 13,12,15,14,9,8,11,10
    writeBurst(8'd13, 2'd3, 1'b1, 32'd200, 4'h0);
    idle(2);
    readOne(8'd8, 4'h0, d, oe);  chk("R3 ilv col8", d, 32'd205);
    idle(4);
    readOne(8'd14, 4'h0, d, oe); chk("R3 ilv col14", d, 32'd203);
    idle(4);

    // R7: masked single write
    writeBurst(8'd20, 2'd0, 1'b0, 32'h11223344, 4'b0101);
    idle(2);
    readOne(8'd20, 4'h0, d, oe);
    chk("R7 write mask", d, {8'h11, initVal(8'd20)[23:16], 8'h33, initVal(8'd20)[7:0]});
    idle(4);

    // R8: write burst at 32 cut off by a read on its third beat
    cmdValid = 1; cmdWrite = 1; cmdCol = 8'd32; burstLenSel = 3; burstOrder = 0; wrData = 32'd300;
    @(negedge clk);
    cmdValid = 0; wrData = 32'd301;
    @(negedge clk);
    cmdValid = 1; cmdWrite = 0; cmdCol = 8'd50; burstLenSel = 0; wrData = 32'd302;
    @(negedge clk);
    cmdValid = 0;
    idle(8);
    readOne(8'd34, 4'h0, d, oe); chk("R8 aborted col34 kept", d, initVal(8'd34));
    idle(4);
    readOne(8'd33, 4'h0, d, oe); chk("R8 col33 written", d, 32'd301);
    idle(4);

    // R6: mask on the read command edge blanks lane 3 of the CL=2 output
    readOne(8'd40, 4'b1000, d, oe);
    chk("R6 read mask data", d, initVal(8'd40) & 32'h00FFFFFF);
    chk("R6 read mask oe", {31'b0, oe}, 32'h1);
    idle(4);

    // R5: two 2-beat reads back to back, oe high 4 cycles then low
    begin
      int cnt;
      cmdValid = 1; cmdWrite = 0; cmdCol = 8'd0; burstLenSel = 1; burstOrder = 0;
      @(negedge clk);
      cmdValid = 0;
      @(negedge clk);
      cmdValid = 1; cmdCol = 8'd2;
      @(negedge clk);
      cmdValid = 0;
      cnt = 0;
      for (int i = 0; i < 4; i++) begin
        if (rdDataOe) cnt++;
        @(negedge clk);
      end
      chk("R5 gapless oe count", 32'(cnt), 32'd4);
      chk("R5 oe drops after burst", {31'b0, rdDataOe}, 32'h0);
    end
    idle(4);

    // R2: latency 3, not yet valid one cycle early
    casLatency = 2'd3;
    idle(2);
    cmdValid = 1; cmdWrite = 0; cmdCol = 8'd60; burstLenSel = 0;
    @(negedge clk);
    cmdValid = 0;
    idle(2);
    chk("R2 CL3 early oe", {31'b0, rdDataOe}, 32'h0);
    @(negedge clk);
    chk("R2 CL3 oe", {31'b0, rdDataOe}, 32'h1);
    chk("R2 CL3 data", rdData, initVal(8'd60));
    idle(6);

    // constrained random traffic for each latency (R2 R3 R4 R5 R6 R7 R8 via model)
    for (int cl = 1; cl <= 3; cl++) begin
      casLatency = 2'(cl);
      idle(2);
      for (int n = 0; n < 500; n++) begin
        cmdValid    = ($urandom % 100) < 30;
        cmdWrite    = $urandom % 2;
        cmdCol      = 8'($urandom);
        burstLenSel = 2'($urandom);
        burstOrder  = 1'($urandom);
        wrData      = $urandom;
        byteMask    = (($urandom % 100) < 20) ? 4'($urandom) : 4'h0;
        @(negedge clk);
      end
      cmdValid = 0; byteMask = 0;
      idle(12);
    end

    chkEn = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule